// File: doc/BRIEF.md
# Burst-Arbitrated Byte DMA Controller

This block is a small multi-channel DMA engine. Each channel copies bytes from one fixed peripheral data-register address into a memory buffer whose address rises by one for every byte. Software programs each channel with four things: a source address, a destination address, an item count and a burst-size code. Software then arms the channel. From then on a level request line from the peripheral lets the channel run. A channel armed with the software bit set runs with no peripheral request at all.

All channels share one bus master port. Each item takes two accesses on that port: a read of the source, then a write of that byte to the destination. A grant input lets a higher-priority processor hold off any single access, even in the middle of a burst, and the engine resumes exactly where it stopped. Priority between channels is decided only between bursts, and the lowest-numbered eligible channel wins. When a channel has moved its full count it disarms itself. A peripheral channel then raises a one-cycle done pulse, and a software channel raises a shared software-completion interrupt.

Software can stop a channel at any time and read back how many items remain, so the number moved is the programmed count minus that remainder. A program command aimed at the channel that currently owns the bus is ignored. Burst codes above 10 are treated as 10.

Top module: `burst_dma_ctrl`

## Requirements
- R1: A burst moves min(2^code, remaining) items, where code is the 4-bit `cfg_arb` value 0..10, so bursts run from 1 to 1024 items. The final burst is shortened to whatever remains. Between bursts `m_req` is low for exactly one arbitration cycle.
- R2: Each item is a read (`m_we`=0) from the channel's fixed source address, followed by a write (`m_we`=1) of the byte just read to the destination address. The destination address increases by 1 after every item.
- R3: While `m_req` is high and `m_gnt` is low, the pending access holds `m_addr`, `m_we` and `m_wdata` unchanged, and no item is lost or repeated.
- R4: At each burst boundary the lowest-numbered eligible channel wins. A burst in progress is never preempted by a request that arrives during it.
- R5: A peripheral channel that has moved exactly its programmed count disarms itself and pulses its `done` bit for one cycle. Its remaining count then reads 0.
- R6: An armed peripheral channel is eligible only while its `dreq` bit is high. If `dreq` stays low, the channel moves nothing and keeps its count.
- R7: A channel armed with `cfg_sw`=1 runs without `dreq`. On completion it pulses `sw_irq` for one cycle and leaves `done` low.
- R8: A stop command (`cfg_op`=2) disarms the channel. Any burst in flight finishes, no done pulse follows, and `rd_remain` equals the programmed count minus the items written.
- R9: An arm command (`cfg_op`=1) with `cfg_cnt`=0 is ignored: the channel stays unarmed.
- R10: After reset no channel is armed, all counts read 0, and `m_req`, `done` and `sw_irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dreq | input | NCH | Level service request, one bit per channel |
| cfg_op | input | 2 | Command: 0 none, 1 arm, 2 stop, 3 ignored |
| cfg_ch | input | CHW | Channel addressed by the command |
| cfg_src | input | AW | Fixed source address |
| cfg_dst | input | AW | First destination address |
| cfg_cnt | input | CW | Item count |
| cfg_arb | input | 4 | Burst-size code, 2^code items |
| cfg_sw | input | 1 | Software-started channel |
| rd_ch | input | CHW | Channel shown on the read-back outputs |
| rd_remain | output | CW | Remaining item count of `rd_ch` |
| rd_armed | output | 1 | `rd_ch` is armed |
| m_req | output | 1 | Bus access pending |
| m_we | output | 1 | Access is a write |
| m_addr | output | AW | Access address |
| m_wdata | output | DW | Write data |
| m_rdata | input | DW | Read data, valid in the granted read cycle |
| m_gnt | input | 1 | Access completes in this cycle |
| done | output | NCH | One-cycle completion pulse per peripheral channel |
| sw_irq | output | 1 | One-cycle completion pulse for software channels |

## Verification
Several kinds of test are run. A single channel moving 1024 items in 32-item bursts with a full grant checks the burst chopping exactly. Random rounds with random counts, burst codes, destinations and grant duty cycles expose any dependence on stalls and any error in shortening the last burst. A grant held low for many cycles mid-transfer shows whether the pending access freezes in place. Two directed priority orderings, one where requests arrive together and one where a lower-numbered request lands mid-burst, separate boundary-only arbitration from preemption. Stop, zero-count, unrequested and software-started cases each have a port-visible signature in `rd_remain`, `done` and `sw_irq`. A final round with all channels concurrent checks that interleaving never mixes data between buffers.

// File: rtl/burst_dma_ctrl.sv
module burst_dma_ctrl #(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CW  = 11,
  parameter int DW  = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] dreq,
  input  logic [1:0]     cfg_op,
  input  logic [CHW-1:0] cfg_ch,
  input  logic [AW-1:0]  cfg_src,
  input  logic [AW-1:0]  cfg_dst,
  input  logic [CW-1:0]  cfg_cnt,
  input  logic [3:0]     cfg_arb,
  input  logic           cfg_sw,
  input  logic [CHW-1:0] rd_ch,
  output logic [CW-1:0]  rd_remain,
  output logic           rd_armed,
  output logic           m_req,
  output logic           m_we,
  output logic [AW-1:0]  m_addr,
  output logic [DW-1:0]  m_wdata,
  input  logic [DW-1:0]  m_rdata,
  input  logic           m_gnt,
  output logic [NCH-1:0] done,
  output logic           sw_irq
);
  localparam logic [3:0] MAXARB = 4'd10;
  localparam logic [1:0] OP_ARM = 2'd1;
  localparam logic [1:0] OP_STOP = 2'd2;

  typedef enum logic [1:0] {S_ARB, S_RD, S_WR} st_t;

  st_t            st;
  logic [CHW-1:0] cur;
  logic [CW-1:0]  beats;
  logic [DW-1:0]  data_q;
  logic [AW-1:0]  src_q [NCH];
  logic [AW-1:0]  dst_q [NCH];
  logic [CW-1:0]  rem_q [NCH];
  logic [3:0]     arb_q [NCH];
  logic [NCH-1:0] armed_q, sw_q;

  logic [NCH-1:0] elig;
  logic [CHW-1:0] pick;
  logic           any;
  logic [CW:0]    blen;
  logic [CW-1:0]  first_beats;
  logic           cfg_hits_active;

  assign elig = armed_q & (dreq | sw_q);
  assign any  = |elig;

  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (elig[i]) pick = CHW'(i);
  end

  assign blen        = (CW + 1)'(1) << arb_q[pick];
  assign first_beats = ({1'b0, rem_q[pick]} < blen) ? rem_q[pick] : blen[CW-1:0];

  assign cfg_hits_active = (st != S_ARB) ? (cfg_ch == cur) : (any && cfg_ch == pick);

  assign m_req   = (st != S_ARB);
  assign m_we    = (st == S_WR);
  assign m_addr  = (st == S_WR) ? dst_q[cur] : (st == S_RD) ? src_q[cur] : '0;
  assign m_wdata = data_q;

  assign rd_remain = rem_q[rd_ch];
  assign rd_armed  = armed_q[rd_ch];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_ARB;
      cur     <= '0;
      beats   <= '0;
      data_q  <= '0;
      armed_q <= '0;
      sw_q    <= '0;
      done    <= '0;
      sw_irq  <= 1'b0;
      for (int i = 0; i < NCH; i++) begin
        src_q[i] <= '0;
        dst_q[i] <= '0;
        rem_q[i] <= '0;
        arb_q[i] <= '0;
      end
    end else begin
      done   <= '0;
      sw_irq <= 1'b0;
      case (st)
        S_ARB: if (any) begin
          cur   <= pick;
          beats <= first_beats;
          st    <= S_RD;
        end
        S_RD: if (m_gnt) begin
          data_q <= m_rdata;
          st     <= S_WR;
        end
        S_WR: if (m_gnt) begin
          dst_q[cur] <= dst_q[cur] + 1'b1;
          rem_q[cur] <= rem_q[cur] - 1'b1;
          beats      <= beats - 1'b1;
          st         <= (beats == 1) ? S_ARB : S_RD;
          if (rem_q[cur] == 1 && armed_q[cur]) begin
            armed_q[cur] <= 1'b0;
            if (sw_q[cur]) sw_irq <= 1'b1;
            else           done[cur] <= 1'b1;
          end
        end
        default: st <= S_ARB;
      endcase
      if (cfg_op == OP_ARM && !cfg_hits_active && cfg_cnt != 0) begin
        src_q[cfg_ch]   <= cfg_src;
        dst_q[cfg_ch]   <= cfg_dst;
        rem_q[cfg_ch]   <= cfg_cnt;
        arb_q[cfg_ch]   <= (cfg_arb > MAXARB) ? MAXARB : cfg_arb;
        sw_q[cfg_ch]    <= cfg_sw;
        armed_q[cfg_ch] <= 1'b1;
      end else if (cfg_op == OP_STOP) begin
        armed_q[cfg_ch] <= 1'b0;
      end
    end
  end

  assert_hold_under_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && !m_gnt) |=> (m_req && $stable(m_addr) && $stable(m_we) && $stable(m_wdata)));

  assert_gap_after_burst_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WR && m_gnt && beats == 1) |=> !m_req);

  assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WR && m_gnt) |=> (rem_q[cur] == $past(rem_q[cur]) - 1'b1));

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|done) |=> (done == '0));

  assert_sw_not_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sw_irq |-> (done == '0 && !$past(sw_irq)));

  assert_read_after_arb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_req) |-> !m_we);
endmodule

// File: tb/burst_dma_ctrl_tb_top.sv
module burst_dma_ctrl_tb_top;
  localparam int NCH = 4, AW = 16, CW = 11, DW = 8, CHW = 2;

  logic           clk = 0, rst_n = 0;
  logic [NCH-1:0] dreq = '0;
  logic [1:0]     cfg_op = 0;
  logic [CHW-1:0] cfg_ch = 0, rd_ch = 0;
  logic [AW-1:0]  cfg_src = 0, cfg_dst = 0;
  logic [CW-1:0]  cfg_cnt = 0;
  logic [3:0]     cfg_arb = 0;
  logic           cfg_sw = 0;
  logic [CW-1:0]  rd_remain;
  logic           rd_armed, m_req, m_we, m_gnt = 0, sw_irq;
  logic [AW-1:0]  m_addr;
  logic [DW-1:0]  m_wdata, m_rdata;
  logic [NCH-1:0] done;

  burst_dma_ctrl #(.NCH(NCH), .AW(AW), .CW(CW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .dreq(dreq), .cfg_op(cfg_op), .cfg_ch(cfg_ch),
    .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_cnt(cfg_cnt), .cfg_arb(cfg_arb),
    .cfg_sw(cfg_sw), .rd_ch(rd_ch), .rd_remain(rd_remain), .rd_armed(rd_armed),
    .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_rdata(m_rdata), .m_gnt(m_gnt), .done(done), .sw_irq(sw_irq));

  always #2 clk = ~clk;

  int checks = 0, failures = 0, gnt_pct = 100;
  int rdcnt [NCH], wcount [NCH], donecnt [NCH];
  int swcnt = 0, nlog = 0, run = 0, lastch = 0;
  int logch [2048], loglen [2048];
  logic [7:0] mem [4096];

  function automatic logic [7:0] pat(int ch, int i);
    return 8'(ch * 37 + i * 5 + 7);
  endfunction

  function automatic int srcaddr(int ch);
    return 32'hF000 + ch;
  endfunction

  initial for (int i = 0; i < NCH; i++) begin
    rdcnt[i] = 0; wcount[i] = 0; donecnt[i] = 0;
  end

  assign m_rdata = pat(int'(m_addr[1:0]), rdcnt[m_addr[1:0]]);

  always @(negedge clk) m_gnt = (($urandom % 100) < gnt_pct);

  always @(posedge clk) begin
    if (m_req && m_gnt && !m_we) rdcnt[m_addr[1:0]] <= rdcnt[m_addr[1:0]] + 1;
    if (m_req && m_gnt && m_we) begin
      mem[m_addr[11:0]] <= m_wdata;
      wcount[m_addr[11:10]] <= wcount[m_addr[11:10]] + 1;
      run <= run + 1;
      lastch <= int'(m_addr[11:10]);
    end
    if (!m_req && run > 0) begin
      logch[nlog % 2048] <= lastch;
      loglen[nlog % 2048] <= run;
      nlog <= nlog + 1;
      run <= 0;
    end
    for (int c = 0; c < NCH; c++) if (done[c]) donecnt[c] <= donecnt[c] + 1;
    if (sw_irq) swcnt <= swcnt + 1;
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  int b_rd [NCH], b_w [NCH], b_d [NCH], b_dst [NCH], b_cnt [NCH], b_arb [NCH], b_sw [NCH];
  int b_s [NCH], b_log [NCH];

  task automatic cmd(input int op, input int ch, input int src, input int dst,
                     input int cnt, input int arb, input bit sw);
    @(negedge clk);
    cfg_op = 2'(op); cfg_ch = CHW'(ch); cfg_src = AW'(src); cfg_dst = AW'(dst);
    cfg_cnt = CW'(cnt); cfg_arb = 4'(arb); cfg_sw = sw;
    @(negedge clk);
    cfg_op = 0;
  endtask

  task automatic start_ch(input int ch, input int cnt, input int arb, input bit sw,
                          input int off, input bit raise);
    b_rd[ch] = rdcnt[ch]; b_w[ch] = wcount[ch]; b_d[ch] = donecnt[ch];
    b_s[ch] = swcnt; b_log[ch] = nlog; b_dst[ch] = ch * 1024 + off;
    b_cnt[ch] = cnt; b_arb[ch] = arb; b_sw[ch] = sw;
    cmd(1, ch, srcaddr(ch), b_dst[ch], cnt, arb, sw);
    if (raise && !sw) dreq[ch] = 1'b1;
  endtask

  task automatic finish_ch(input int ch, input bit burst_chk);
    int bad, nb, rem, blen;
    for (int t = 0; t < 20000; t++) begin
      if (b_sw[ch] ? (swcnt != b_s[ch]) : (donecnt[ch] != b_d[ch])) break;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
    dreq[ch] = 1'b0;
    chk(wcount[ch] - b_w[ch] == b_cnt[ch], "R2 items written", wcount[ch] - b_w[ch], b_cnt[ch]);
    bad = 0;
    for (int i = 0; i < b_cnt[ch]; i++)
      if (mem[(b_dst[ch] + i) % 4096] !== pat(ch, b_rd[ch] + i)) bad++;
    chk(bad == 0, "R2 destination bytes", bad, 0);
    if (b_sw[ch]) begin
      chk(swcnt - b_s[ch] == 1, "R7 sw_irq pulses", swcnt - b_s[ch], 1);
      chk(donecnt[ch] == b_d[ch], "R7 done stays low", donecnt[ch] - b_d[ch], 0);
    end else begin
      chk(donecnt[ch] - b_d[ch] == 1, "R5 done pulses", donecnt[ch] - b_d[ch], 1);
    end
    rd_ch = CHW'(ch); #1;
    chk(rd_remain == 0 && !rd_armed, "R5 disarmed with zero remaining",
        int'(rd_remain) + (rd_armed ? 10000 : 0), 0);
    if (burst_chk) begin
      nb = 0; bad = 0; rem = b_cnt[ch]; blen = 1 << b_arb[ch];
      for (int k = b_log[ch]; k < nlog; k++) begin
        if (loglen[k % 2048] != ((rem < blen) ? rem : blen) || logch[k % 2048] != ch) bad++;
        rem -= loglen[k % 2048];
        nb++;
      end
      chk(bad == 0 && nb == (b_cnt[ch] + blen - 1) / blen, "R1 burst lengths",
          nb * 1000 + bad, (b_cnt[ch] + blen - 1) / blen * 1000);
    end
  endtask

  task automatic chk_order(input int from, input int n, input int chs [4], input int lens [4], input string what);
    int bad = 0;
    for (int k = 0; k < n; k++)
      if (logch[(from + k) % 2048] != chs[k] || loglen[(from + k) % 2048] != lens[k]) bad++;
    chk(bad == 0 && nlog - from == n, what, (nlog - from) * 100 + bad, n * 100);
  endtask

  initial begin
    int w0, l0, moved;
    int ch, cnt, arb, off;
    bit sw;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R10 reset state
    chk(!m_req && done == 0 && !sw_irq, "R10 outputs idle after reset", {m_req, sw_irq}, 0);
    for (int c = 0; c < NCH; c++) begin
      rd_ch = CHW'(c); #1;
      chk(!rd_armed && rd_remain == 0, "R10 channel cleared", int'(rd_remain) + rd_armed, 0);
    end

    // R9 zero-count arm
    cmd(1, 1, srcaddr(1), 1024, 0, 2, 0);
    rd_ch = 1; #1;
    chk(!rd_armed, "R9 zero count not armed", rd_armed, 0);

    // R6 armed but unrequested
    w0 = wcount[3];
    cmd(1, 3, srcaddr(3), 3072, 5, 1, 0);
    repeat (40) @(negedge clk);
    rd_ch = 3; #1;
    chk(wcount[3] == w0 && rd_remain == 5 && rd_armed, "R6 no service without request",
        wcount[3] - w0 + int'(rd_remain) * 10, 50);
    chk(!m_req, "R6 bus idle without request", m_req, 0);
    cmd(2, 3, 0, 0, 0, 0, 0);

    // R1 R2 R5 1024 items in 32-item bursts
    start_ch(0, 1024, 5, 0, 0, 1);
    finish_ch(0, 1);

    // R3 long stall mid transfer
    gnt_pct = 0;
    start_ch(2, 6, 3, 0, 100, 1);
    repeat (5) @(negedge clk);
    chk(m_req && !m_we && int'(m_addr) == srcaddr(2), "R3 read held under stall",
        int'(m_addr), srcaddr(2));
    repeat (20) @(negedge clk);
    chk(m_req && !m_we && int'(m_addr) == srcaddr(2) && wcount[2] == b_w[2],
        "R3 still held, nothing moved", int'(m_addr), srcaddr(2));
    gnt_pct = 100;
    finish_ch(2, 1);

    // R4 simultaneous requests: lower channel first
    cmd(1, 2, srcaddr(2), 2048 + 900, 8, 2, 0);
    b_rd[0] = rdcnt[0]; b_rd[2] = rdcnt[2];
    cmd(1, 0, srcaddr(0), 900, 8, 2, 0);
    l0 = nlog;
    dreq[0] = 1; dreq[2] = 1;
    repeat (60) @(negedge clk);
    dreq = '0;
    chk_order(l0, 4, '{0, 0, 2, 2}, '{4, 4, 4, 4}, "R4 lowest channel wins at boundaries");

    // R4 request arriving mid burst does not preempt
    cmd(1, 1, srcaddr(1), 1024 + 500, 4, 2, 0);
    w0 = wcount[2];
    cmd(1, 2, srcaddr(2), 2048 + 600, 16, 3, 0);
    l0 = nlog;
    dreq[2] = 1;
    for (int t = 0; t < 100 && wcount[2] == w0; t++) @(negedge clk);
    dreq[1] = 1;
    repeat (80) @(negedge clk);
    dreq = '0;
    chk_order(l0, 3, '{2, 1, 2, 0}, '{8, 4, 8, 0}, "R4 no preemption mid burst");

    // R7 software start
    start_ch(3, 13, 2, 1, 200, 0);
    finish_ch(3, 1);

    // R8 stop mid transfer
    start_ch(1, 20, 0, 0, 0, 1);
    for (int t = 0; t < 200 && wcount[1] - b_w[1] < 5; t++) @(negedge clk);
    cmd(2, 1, 0, 0, 0, 0, 0);
    repeat (10) @(negedge clk);
    dreq[1] = 0;
    moved = wcount[1] - b_w[1];
    rd_ch = 1; #1;
    chk(int'(rd_remain) == 20 - moved && moved < 20, "R8 remaining equals count minus moved",
        int'(rd_remain), 20 - moved);
    chk(!rd_armed && donecnt[1] == b_d[1], "R8 stopped without done",
        rd_armed + donecnt[1] - b_d[1], 0);
    dreq[1] = 1;
    repeat (20) @(negedge clk);
    dreq[1] = 0;
    chk(wcount[1] - b_w[1] == moved, "R8 stopped channel stays idle", wcount[1] - b_w[1], moved);

    // random single-channel rounds, R1 R2 R3 R5 R7
    for (int r = 0; r < 14; r++) begin
      ch = $urandom % NCH;
      cnt = 1 + $urandom % 80;
      arb = $urandom % 8;
      sw = (($urandom % 4) == 0);
      off = $urandom % (1024 - cnt);
      gnt_pct = 40 + $urandom % 61;
      start_ch(ch, cnt, arb, sw, off, 1);
      finish_ch(ch, 1);
    end

    // all channels concurrent, R2 R4 R5
    gnt_pct = 70;
    for (int c = 0; c < NCH; c++) start_ch(c, 10 + c * 7, c, 0, 300 + c * 3, 1);
    for (int c = 0; c < NCH; c++) finish_ch(c, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule